// File: doc/BRIEF.md
# Synchronous Memory Card Power-Up Sequencer

This block brings up the contacts of a synchronous (type 2) memory smartcard. On a start command issued while idle, it switches the card supply on at a requested level. It then emits a single timed clock pulse while the supply ramps, and keeps C4 low until a fixed window after that pulse has passed. From then on the card clock comes from the host's clock settings. Once the supply is reported stable, the IO pull-up and the C8 level are applied.

Activation completes when C4 has been released and the supply is stable. At that point a sync-complete status flag is set and the active-low interrupt line is pulled low. From then on the host drives the reset contact, and the IO line may be connected to the host channel. RST is never raised by the sequencer itself. Writing one to clear the flag releases the interrupt line. The card then stays powered and under host control until reset.

All delays come from a 1 µs tick that is prescaled from the system clock and restarted at every phase change. The delays use nominal values: 10 µs from supply to clock pulse, 9 µs clock high, and 18 µs from the end of the pulse to the release of C4.

Top module: `sync_card_activator`

## Requirements
- R1: While idle, vcc_en_o, vcc_sel_o, card_clk_o, card_rst_o, card_c4_o, card_c8_o, io_pullup_o, io_connect_o and sync_done_o are 0 and irq_n_o is 1, whatever the other inputs are.
- R2: A start_i sampled high while idle raises vcc_en_o on that clock edge. vcc_sel_o then shows the 2-bit vsel_i value captured on that edge, and holds it while powered even if vsel_i changes.
- R3: card_clk_o rises exactly T_RAMP_US µs (T_RAMP_US*CLK_PER_US clocks) after vcc_en_o rises.
- R4: card_clk_o stays high for exactly T_PULSE_US µs, and this is the only high pulse before C4 is released.
- R5: card_c4_o stays low until exactly T_HOLD_US µs after card_clk_o falls, then goes high and stays high.
- R6: Once card_c4_o is high, card_clk_o equals host_clk_i.
- R7: io_pullup_o is 1 exactly when the supply is on and vcc_stable_i is 1. card_c8_o is c8_cfg_i under the same condition and 0 otherwise.
- R8: io_connect_o is 1 only when activation is complete, io_en_i is 1 and vcc_stable_i is 1.
- R9: sync_done_o goes to 1 and irq_n_o goes to 0 one clock after both card_c4_o and vcc_stable_i are high.
- R10: card_rst_o is 0 until sync_done_o is set. From then on it equals host_rst_i.
- R11: A start_i pulse while a sequence is running or after completion changes no output timing or level.
- R12: irq_clr_i while sync_done_o is 1 clears it on the next edge, so irq_n_o returns to 1. Supply, C4 and host control of the contacts then stay as they are until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Activation request |
| vcc_stable_i | input | 1 | Card supply reported stable |
| vsel_i | input | 2 | Supply level code from the card control field |
| io_en_i | input | 1 | IO connection enable from the card control field |
| c8_cfg_i | input | 1 | C8 level from its configuration field |
| host_clk_i | input | 1 | Card clock as set by the clock settings register |
| host_rst_i | input | 1 | Host-controlled reset level |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the status flag |
| vcc_en_o | output | 1 | Card supply enable |
| vcc_sel_o | output | 2 | Card supply level code |
| card_clk_o | output | 1 | Card CLK contact |
| card_rst_o | output | 1 | Card RST contact |
| card_c4_o | output | 1 | Card C4 contact |
| card_c8_o | output | 1 | Card C8 contact |
| io_pullup_o | output | 1 | IO pull-up to card supply enabled |
| io_connect_o | output | 1 | IO joined to the host IO channel |
| sync_done_o | output | 1 | Sync-complete status flag |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with CLK_PER_US=3 and the nominal delays of 10, 9 and 18 µs. One activation therefore takes about 110 clocks. This makes it affordable to sweep every supply code, both IO-enable levels, both C8 levels and both early and late supply-stable arrival. Every case is observed cycle by cycle. The small divider still leaves a multi-cycle tick, so an off-by-one in the prescaler or in a phase counter moves an edge by a whole number of clocks, and the bench reports it.

// File: rtl/sca_pkg.sv
package sca_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAMP,
        ST_PULSE,
        ST_HOLD,
        ST_SETTLE,
        ST_DONE,
        ST_LIVE
    } sca_state_e;

    typedef struct packed {
        logic       vcc_en;
        logic [1:0] vcc_sel;
        logic       clk;
        logic       rst;
        logic       c4;
        logic       c8;
        logic       io_pu;
        logic       io_con;
    } contact_t;

    function automatic logic host_owned(sca_state_e s);
        return (s == ST_DONE) || (s == ST_LIVE);
    endfunction

    function automatic logic c4_released(sca_state_e s);
        return (s == ST_SETTLE) || (s == ST_DONE) || (s == ST_LIVE);
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sca_tick_gen.sv
module sca_tick_gen #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int W = $clog2(DIV);
            localparam logic [W-1:0] LAST = W'(DIV - 1);
            logic [W-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || restart_i) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick_o = (cnt_q == LAST);

            AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (rst)
                cnt_q <= LAST);  // R3
        end
    endgenerate
endmodule

// File: rtl/sca_sequencer.sv
module sca_sequencer
    import sca_pkg::*;
#(
    parameter int T_RAMP_US  = 10,
    parameter int T_PULSE_US = 9,
    parameter int T_HOLD_US  = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       tick_i,
    input  logic       vcc_stable_i,
    input  logic       irq_clr_i,
    output sca_state_e state_o,
    output logic       phase_change_o
);
    localparam int MAXL = max3(T_RAMP_US, T_PULSE_US, T_HOLD_US);
    localparam int UW   = $clog2(MAXL + 1);

    sca_state_e     state_q, state_d;
    logic [UW-1:0]  us_q;
    logic [UW-1:0]  limit;
    logic           timed;
    logic           expire;

    always_comb begin
        timed = 1'b1;
        unique case (state_q)
            ST_RAMP:  limit = UW'(T_RAMP_US);
            ST_PULSE: limit = UW'(T_PULSE_US);
            ST_HOLD:  limit = UW'(T_HOLD_US);
            default: begin
                limit = '0;
                timed = 1'b0;
            end
        endcase
    end

    assign expire = timed && tick_i && (us_q == limit - 1'b1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)      state_d = ST_RAMP;
            ST_RAMP:   if (expire)       state_d = ST_PULSE;
            ST_PULSE:  if (expire)       state_d = ST_HOLD;
            ST_HOLD:   if (expire)       state_d = ST_SETTLE;
            ST_SETTLE: if (vcc_stable_i) state_d = ST_DONE;
            ST_DONE:   if (irq_clr_i)    state_d = ST_LIVE;
            ST_LIVE:                     state_d = ST_LIVE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    assign phase_change_o = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            us_q    <= '0;
        end else begin
            state_q <= state_d;
            if (phase_change_o) begin
                us_q <= '0;
            end else if (timed && tick_i) begin
                us_q <= us_q + 1'b1;
            end
        end
    end

    assign state_o = state_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        timed |-> (us_q < limit));  // R5
    AST_NO_RETURN: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (state_q != ST_IDLE));  // R12
    AST_LIVE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LIVE) |=> (state_q == ST_LIVE));  // R11
endmodule

// File: rtl/sca_contact_drv.sv
module sca_contact_drv
    import sca_pkg::*;
(
    input  sca_state_e state_i,
    input  logic [1:0] vsel_q_i,
    input  logic       vcc_stable_i,
    input  logic       host_clk_i,
    input  logic       host_rst_i,
    input  logic       io_en_i,
    input  logic       c8_cfg_i,
    output contact_t   pins_o
);
    logic powered;
    logic stable_on;

    assign powered   = (state_i != ST_IDLE);
    assign stable_on = powered && vcc_stable_i;

    always_comb begin
        pins_o         = '0;
        pins_o.vcc_en  = powered;
        pins_o.vcc_sel = powered ? vsel_q_i : 2'b00;
        if (state_i == ST_PULSE) begin
            pins_o.clk = 1'b1;
        end else if (c4_released(state_i)) begin
            pins_o.clk = host_clk_i;
        end
        pins_o.c4     = c4_released(state_i);
        pins_o.rst    = host_owned(state_i) && host_rst_i;
        pins_o.io_pu  = stable_on;
        pins_o.c8     = stable_on && c8_cfg_i;
        pins_o.io_con = host_owned(state_i) && io_en_i && stable_on;
    end
endmodule

// File: rtl/sync_card_activator.sv
module sync_card_activator
    import sca_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int T_RAMP_US  = 10,
    parameter int T_PULSE_US = 9,
    parameter int T_HOLD_US  = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       vcc_stable_i,
    input  logic [1:0] vsel_i,
    input  logic       io_en_i,
    input  logic       c8_cfg_i,
    input  logic       host_clk_i,
    input  logic       host_rst_i,
    input  logic       irq_clr_i,
    output logic       vcc_en_o,
    output logic [1:0] vcc_sel_o,
    output logic       card_clk_o,
    output logic       card_rst_o,
    output logic       card_c4_o,
    output logic       card_c8_o,
    output logic       io_pullup_o,
    output logic       io_connect_o,
    output logic       sync_done_o,
    output logic       irq_n_o
);
    sca_state_e state;
    logic       phase_change;
    logic       tick;
    logic [1:0] vsel_q;
    contact_t   pins;

    sca_tick_gen #(.DIV(CLK_PER_US)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .restart_i (phase_change),
        .tick_o    (tick)
    );

    sca_sequencer #(
        .T_RAMP_US  (T_RAMP_US),
        .T_PULSE_US (T_PULSE_US),
        .T_HOLD_US  (T_HOLD_US)
    ) u_seq (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .tick_i         (tick),
        .vcc_stable_i   (vcc_stable_i),
        .irq_clr_i      (irq_clr_i),
        .state_o        (state),
        .phase_change_o (phase_change)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vsel_q <= 2'b00;
        end else if (state == ST_IDLE && start_i) begin
            vsel_q <= vsel_i;
        end
    end

    sca_contact_drv u_drv (
        .state_i      (state),
        .vsel_q_i     (vsel_q),
        .vcc_stable_i (vcc_stable_i),
        .host_clk_i   (host_clk_i),
        .host_rst_i   (host_rst_i),
        .io_en_i      (io_en_i),
        .c8_cfg_i     (c8_cfg_i),
        .pins_o       (pins)
    );

    assign vcc_en_o     = pins.vcc_en;
    assign vcc_sel_o    = pins.vcc_sel;
    assign card_clk_o   = pins.clk;
    assign card_rst_o   = pins.rst;
    assign card_c4_o    = pins.c4;
    assign card_c8_o    = pins.c8;
    assign io_pullup_o  = pins.io_pu;
    assign io_connect_o = pins.io_con;
    assign sync_done_o  = (state == ST_DONE);
    assign irq_n_o      = !sync_done_o;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!vcc_en_o && !card_clk_o && !card_c4_o
                                && !io_pullup_o && irq_n_o));  // R1
    AST_VSEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (vcc_en_o && $past(vcc_en_o)) |-> $stable(vcc_sel_o));  // R2
    AST_CLK_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> !card_clk_o);  // R4
    AST_RST_HELD: assert property (@(posedge clk) disable iff (rst)
        !host_owned(state) |-> !card_rst_o);  // R10
    AST_IRQ_CONTEXT: assert property (@(posedge clk) disable iff (rst)
        !irq_n_o |-> (card_c4_o && vcc_en_o));  // R9
    AST_CONNECT_GATED: assert property (@(posedge clk) disable iff (rst)
        io_connect_o |-> (io_en_i && io_pullup_o));  // R8
endmodule

// File: tb/sim_sync_card_activator.sv
module sim_sync_card_activator;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;
    localparam int RAMP       = 10;
    localparam int PULSE      = 9;
    localparam int HOLD       = 18;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 0, vcc_stable_i = 0, io_en_i = 0, c8_cfg_i = 0;
    logic       host_clk_i = 0, host_rst_i = 0, irq_clr_i = 0;
    logic [1:0] vsel_i = 2'b00;
    logic       vcc_en_o, card_clk_o, card_rst_o, card_c4_o, card_c8_o;
    logic       io_pullup_o, io_connect_o, sync_done_o, irq_n_o;
    logic [1:0] vcc_sel_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_card_activator #(
        .CLK_PER_US(DIV), .T_RAMP_US(RAMP), .T_PULSE_US(PULSE), .T_HOLD_US(HOLD)
    ) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .vcc_stable_i(vcc_stable_i),
        .vsel_i(vsel_i), .io_en_i(io_en_i), .c8_cfg_i(c8_cfg_i),
        .host_clk_i(host_clk_i), .host_rst_i(host_rst_i), .irq_clr_i(irq_clr_i),
        .vcc_en_o(vcc_en_o), .vcc_sel_o(vcc_sel_o), .card_clk_o(card_clk_o),
        .card_rst_o(card_rst_o), .card_c4_o(card_c4_o), .card_c8_o(card_c8_o),
        .io_pullup_o(io_pullup_o), .io_connect_o(io_connect_o),
        .sync_done_o(sync_done_o), .irq_n_o(irq_n_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        start_i = 0; irq_clr_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_one(input logic [1:0] vs, input logic ioe,
                           input logic c8v, input logic late);
        int t_rise = -1, t_fall = -1, t_c4 = -1, t_done = -1, hi_cnt = 0;
        int bad_follow = 0, bad_rst = 0, bad_pu = 0, bad_con = 0, bad_sel = 0;
        int st_at;
        int exp_done;
        logic stable_now;
        st_at = late ? 150 : 5;
        exp_done = late ? 151 : (RAMP + PULSE + HOLD) * DIV + 1;
        do_reset();
        vsel_i = vs; io_en_i = ioe; c8_cfg_i = c8v; vcc_stable_i = 0;
        host_rst_i = 0; host_clk_i = 0;
        start_i = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            start_i    = (i == 40);
            vsel_i     = (i >= 3) ? ~vs : vs;
            host_clk_i = ((i % 3) == 1);
            host_rst_i = ((i % 4) < 2);
            if (i == st_at) vcc_stable_i = 1'b1;
            #1;
            stable_now = (i >= st_at);
            if (t_done < 0 && !irq_n_o) t_done = i;
            if (t_c4 < 0 && card_c4_o) t_c4 = i;
            if (t_c4 < 0) begin
                if (card_clk_o) hi_cnt++;
                if (t_rise < 0 && card_clk_o) t_rise = i;
                if (t_rise >= 0 && t_fall < 0 && !card_clk_o) t_fall = i;
            end else if (card_clk_o != host_clk_i) begin
                bad_follow++;
            end
            if (t_c4 >= 0 && !card_c4_o) bad_follow++;
            if (card_rst_o != ((t_done >= 0) ? host_rst_i : 1'b0)) bad_rst++;
            if (io_pullup_o != stable_now || card_c8_o != (stable_now && c8v)) bad_pu++;
            if (io_connect_o != ((t_done >= 0) && ioe && stable_now)) bad_con++;
            if (!vcc_en_o || vcc_sel_o != vs) bad_sel++;
        end
        start_i = 0;
        chk("R2 supply on with captured level code", bad_sel, 0);
        chk("R3 CLK rise time (clocks after supply)", t_rise, RAMP * DIV);
        chk("R4 CLK fall time", t_fall, (RAMP + PULSE) * DIV);
        chk("R4 single pulse high clocks", hi_cnt, PULSE * DIV);
        chk("R5 C4 release time", t_c4, (RAMP + PULSE + HOLD) * DIV);
        chk("R6 CLK follows host after C4 / C4 stays high", bad_follow, 0);
        chk("R7 pull-up and C8 gating", bad_pu, 0);
        chk("R8 IO connection gating", bad_con, 0);
        chk("R9 completion interrupt time", t_done, exp_done);
        chk("R10 RST held low then host-controlled", bad_rst, 0);
        chk("R11 mid-sequence start had no effect (flag up)", sync_done_o, 1);
        // R12: write-one-to-clear, then remain active and ignore start
        @(negedge clk);
        irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
        #1;
        chk("R12 flag cleared", sync_done_o, 0);
        chk("R12 interrupt released", irq_n_o, 1);
        begin
            int bad_live = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                start_i = (k == 2);
                host_clk_i = (k % 2 == 0);
                #1;
                if (!vcc_en_o || !card_c4_o || !irq_n_o || card_clk_o != host_clk_i
                    || card_rst_o != host_rst_i) bad_live++;
            end
            start_i = 0;
            chk("R11 R12 stays active after clear, start ignored", bad_live, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1: idle stays quiet with every other input high
        vcc_stable_i = 1; c8_cfg_i = 1; io_en_i = 1; host_clk_i = 1;
        host_rst_i = 1; vsel_i = 2'b11; irq_clr_i = 1;
        begin
            int bad_idle = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                #1;
                if (vcc_en_o || vcc_sel_o != 2'b00 || card_clk_o || card_rst_o
                    || card_c4_o || card_c8_o || io_pullup_o || io_connect_o
                    || sync_done_o || !irq_n_o) bad_idle++;
            end
            chk("R1 idle outputs quiet", bad_idle, 0);
        end
        irq_clr_i = 0;
        for (int c = 0; c < 32; c++) begin
            run_one(c[1:0], c[2], c[3], c[4]);
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule